// File: doc/BRIEF.md
# Flash Read-Configuration Register with Bank-Scoped Readback

This block holds the 16-bit word that configures read accesses of a dual-bank flash command interface. The word lives outside the memory map. A decoded "configuration write" command loads it from the low half of the 32-bit command data bus, and a decoded "configuration readback" command switches one bank so that its reads return the word instead of array contents. The decoded fields drive the read-path logic: synchronous or asynchronous mode, initial burst delay, delivery clock edge, wait setting, burst sequence, latency indication and burst length.

Writes are dropped without trace while the embedded program/erase engine reports busy. The readback command latches the bank address presented with it. Only that bank then answers with the register, and the other bank keeps returning array data. This holds until an "array mode" command or a hardware reset. Reserved fields are forced to fixed values on load, so the stored word always holds a legal setting.

Command encoding on `cmd_op`, sampled when `cmd_vld` is high: 2'b01 writes the register, 2'b10 enters readback mode for `cmd_bank`, 2'b11 returns both banks to array reads, and 2'b00 does nothing.

Top module: `flash_cfg_port`

## Requirements
- R1: After hardware reset, `cfg_word` is 16'h9C40: bit 15 = 1 (asynchronous, so `sync_burst_en` = 0), bits 13..10 = 4'b0111 (`burst_delay_clks` = 9), bit 9 = 0, bit 6 = 1 (`rise_edge` = 1), all other bits 0. Reads return array data.
- R2: A write command (`cmd_op` = 2'b01) with `busy` low loads `cmd_data[15:0]` at the clock edge where it is sampled, visible on `cfg_word` from that edge. `cmd_data[31:16]` has no effect.
- R3: A write command sampled while `busy` is high leaves `cfg_word` and every decoded field unchanged.
- R4: Field decode: `sync_burst_en` = NOT bit 15; `burst_delay_clks` = bits 13..10 plus 2; `wait_cfg` = bit 8; `burst_seq` = bit 7; `rise_edge` = bit 6; `ind_latency` = bit 3; `burst_len` = bits 2..0.
- R5: Bits 14, 9, 5 and 4 of the stored word are always 0, whatever value is written to them.
- R6: After a readback command (`cmd_op` = 2'b10) on bank B, every read to bank B returns {16'h0000, `cfg_word`} with `rd_is_cfg` = 1. Reads to the other bank return `arr_data` with `rd_is_cfg` = 0.
- R7: Readback mode persists across register writes and further reads. It ends only on an array-mode command (`cmd_op` = 2'b11) or a hardware reset. A new readback command moves it to the newly given bank.
- R8: `rd_valid`, `rd_data` and `rd_is_cfg` update one clock after a sampled `rd_req`. `rd_valid` is 0 in a cycle that follows no request.
- R9: With `word_mode` = 1, array reads return zero on `rd_data[31:16]` and `arr_data[15:0]` on the low half.
- R10: A register write made while in readback mode is returned by the next readback read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_vld | input | 1 | Decoded command strobe |
| cmd_op | input | 2 | Command type: 01 write, 10 readback entry, 11 array mode |
| cmd_bank | input | 1 | Bank address latched with the command |
| cmd_data | input | 32 | Command data bus; low 16 bits carry the register |
| word_mode | input | 1 | 1 = 16-bit bus, upper half of array reads zeroed |
| busy | input | 1 | Embedded program/erase engine active |
| rd_req | input | 1 | Read request this cycle |
| rd_bank | input | 1 | Bank address of the read |
| arr_data | input | 32 | Data from the flash array |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Read result |
| rd_is_cfg | output | 1 | Read result came from the register |
| cfg_word | output | 16 | Stored register word |
| sync_burst_en | output | 1 | Synchronous burst reads enabled |
| burst_delay_clks | output | 5 | Initial burst access delay in clocks |
| wait_cfg | output | 1 | Wait configuration bit |
| burst_seq | output | 1 | Burst sequence bit |
| rise_edge | output | 1 | 1 = data on rising edge, 0 = falling |
| ind_latency | output | 1 | Indicated latency bit |
| burst_len | output | 3 | Burst length code |

## Verification
A command sampled at a rising edge changes `cfg_word` and the decoded fields at that same edge. The bench drives the command on a falling edge, removes it on the next falling edge and checks the outputs there. A readback entry affects only reads sampled at later edges, so read checks are issued at least one edge after the command. Each read result is due exactly one edge after `rd_req` is sampled, and the bench samples `rd_valid`, `rd_data` and `rd_is_cfg` at the falling edge that follows. Reset release passes a two-stage synchronizer, so the bench waits several clocks before its first check.

// File: rtl/flash_cfg_pkg.sv
package flash_cfg_pkg;

  localparam int CFG_W = 16;

  // Command types carried on cmd_op
  typedef enum logic [1:0] {
    OP_NOP    = 2'b00,
    OP_CFG_WR = 2'b01,
    OP_CFG_RD = 2'b10,
    OP_ARRAY  = 2'b11
  } cfg_op_e;

  // Field positions inside the register word
  localparam int POS_MODE   = 15;
  localparam int POS_DLY_LO = 10;
  localparam int POS_DLY_HI = 13;
  localparam int POS_WAIT   = 8;
  localparam int POS_SEQ    = 7;
  localparam int POS_EDGE   = 6;
  localparam int POS_IND    = 3;
  localparam int POS_LEN_HI = 2;

  // Reset value: asynchronous mode, delay code 7, rising edge
  localparam logic [CFG_W-1:0] CFG_DEFAULT = 16'h9C40;
  // Bits that take the written value; bits 14, 9, 5, 4 are forced to 0
  localparam logic [CFG_W-1:0] CFG_KEEP    = 16'hBDCF;

  typedef struct packed {
    logic       async_mode;
    logic [3:0] dly_code;
    logic       wait_cfg;
    logic       burst_seq;
    logic       rise_edge;
    logic       ind_lat;
    logic [2:0] burst_len;
  } cfg_fields_t;

endpackage

// File: rtl/fcr_rst_sync.sv
module fcr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/fcr_store.sv
module fcr_store
  import flash_cfg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cmd,
  input  logic              busy,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CFG_W-1:0]  cfg_q
);

  logic             load_en;
  logic [CFG_W-1:0] cfg_d;
  logic             unused_hi;

  // Upper half of the data bus never reaches the register
  assign unused_hi = ^wr_data[DATA_W-1:CFG_W];

  // Next-state: gate on engine idle, force reserved fields to 0
  always_comb begin
    load_en = wr_cmd && !busy;
    cfg_d   = cfg_q;
    if (load_en) begin
      cfg_d = wr_data[CFG_W-1:0] & CFG_KEEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_DEFAULT;
    end else if (load_en) begin
      cfg_q <= cfg_d;
    end
  end

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && busy) |=> $stable(cfg_q)); // R3

  AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !busy) |=> (cfg_q[15] == $past(wr_data[15]) &&
                           cfg_q[13:10] == $past(wr_data[13:10]) &&
                           cfg_q[2:0] == $past(wr_data[2:0]))); // R2

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[14] == 1'b0 && cfg_q[9] == 1'b0 && cfg_q[5:4] == 2'b00)); // R5

endmodule

// File: rtl/fcr_bank_sel.sv
module fcr_bank_sel #(
  parameter int BANK_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enter_cmd,
  input  logic              leave_cmd,
  input  logic [BANK_W-1:0] cmd_bank,
  output logic              cfg_mode_q,
  output logic [BANK_W-1:0] bank_q
);

  logic              mode_d;
  logic [BANK_W-1:0] bank_d;
  logic              upd_en;

  always_comb begin
    mode_d = cfg_mode_q;
    bank_d = bank_q;
    upd_en = enter_cmd || leave_cmd;
    if (leave_cmd) begin
      mode_d = 1'b0;
    end else if (enter_cmd) begin
      mode_d = 1'b1;
      bank_d = cmd_bank;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_mode_q <= 1'b0;
      bank_q     <= '0;
    end else if (upd_en) begin
      cfg_mode_q <= mode_d;
      bank_q     <= bank_d;
    end
  end

  AST_LEAVE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    leave_cmd |=> !cfg_mode_q); // R7

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!enter_cmd && !leave_cmd) |=> ($stable(cfg_mode_q) && $stable(bank_q))); // R7

  AST_ENTER_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_cmd && !leave_cmd) |=> (cfg_mode_q && bank_q == $past(cmd_bank))); // R6

endmodule

// File: rtl/fcr_read_mux.sv
module fcr_read_mux
  import flash_cfg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BANK_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [DATA_W-1:0] arr_data,
  input  logic              word_mode,
  input  logic              cfg_mode,
  input  logic [BANK_W-1:0] cfg_bank,
  input  logic [CFG_W-1:0]  cfg_word,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_is_cfg
);

  localparam int LANES = DATA_W / CFG_W;

  logic              hit;
  logic [DATA_W-1:0] data_d;

  assign hit = cfg_mode && (rd_bank == cfg_bank);

  // Lane 0 carries the register or low array half; upper lanes zero on
  // a register hit or in 16-bit bus mode
  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    if (ln == 0) begin : g_low
      always_comb begin
        data_d[CFG_W-1:0] = hit ? cfg_word : arr_data[CFG_W-1:0];
      end
    end else begin : g_high
      always_comb begin
        data_d[ln*CFG_W +: CFG_W] = (hit || word_mode) ? '0
                                    : arr_data[ln*CFG_W +: CFG_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data   <= '0;
      rd_is_cfg <= 1'b0;
    end else if (rd_req) begin
      rd_data   <= data_d;
      rd_is_cfg <= hit;
    end
  end

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid); // R8

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid); // R8

  AST_CFG_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_is_cfg) |-> (rd_data[DATA_W-1:CFG_W] == '0)); // R6

  AST_WORD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && word_mode) |=> (rd_data[DATA_W-1:CFG_W] == '0)); // R9

endmodule

// File: rtl/flash_cfg_port.sv
module flash_cfg_port
  import flash_cfg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BANK_W = 1,
  parameter int DLY_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_vld,
  input  logic [1:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              word_mode,
  input  logic              busy,
  input  logic              rd_req,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [DATA_W-1:0] arr_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_is_cfg,
  output logic [15:0]       cfg_word,
  output logic              sync_burst_en,
  output logic [DLY_W-1:0]  burst_delay_clks,
  output logic              wait_cfg,
  output logic              burst_seq,
  output logic              rise_edge,
  output logic              ind_latency,
  output logic [2:0]        burst_len
);

  localparam logic [DLY_W-1:0] DLY_BASE = DLY_W'(2);

  logic             rst_sync_n;
  logic             wr_cmd;
  logic             enter_cmd;
  logic             leave_cmd;
  logic [CFG_W-1:0] cfg_q;
  logic             cfg_mode;
  logic [BANK_W-1:0] cfg_bank;
  cfg_fields_t      fld;

  fcr_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Command strobe decode
  always_comb begin
    wr_cmd    = cmd_vld && (cmd_op == OP_CFG_WR);
    enter_cmd = cmd_vld && (cmd_op == OP_CFG_RD);
    leave_cmd = cmd_vld && (cmd_op == OP_ARRAY);
  end

  fcr_store #(.DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_cmd  (wr_cmd),
    .busy    (busy),
    .wr_data (cmd_data),
    .cfg_q   (cfg_q)
  );

  fcr_bank_sel #(.BANK_W(BANK_W)) u_bank_sel (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .enter_cmd  (enter_cmd),
    .leave_cmd  (leave_cmd),
    .cmd_bank   (cmd_bank),
    .cfg_mode_q (cfg_mode),
    .bank_q     (cfg_bank)
  );

  fcr_read_mux #(.DATA_W(DATA_W), .BANK_W(BANK_W)) u_read_mux (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rd_req    (rd_req),
    .rd_bank   (rd_bank),
    .arr_data  (arr_data),
    .word_mode (word_mode),
    .cfg_mode  (cfg_mode),
    .cfg_bank  (cfg_bank),
    .cfg_word  (cfg_q),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .rd_is_cfg (rd_is_cfg)
  );

  // Field extraction
  always_comb begin
    fld.async_mode = cfg_q[POS_MODE];
    fld.dly_code   = cfg_q[POS_DLY_HI:POS_DLY_LO];
    fld.wait_cfg   = cfg_q[POS_WAIT];
    fld.burst_seq  = cfg_q[POS_SEQ];
    fld.rise_edge  = cfg_q[POS_EDGE];
    fld.ind_lat    = cfg_q[POS_IND];
    fld.burst_len  = cfg_q[POS_LEN_HI:0];
  end

  always_comb begin
    cfg_word         = cfg_q;
    sync_burst_en    = !fld.async_mode;
    burst_delay_clks = DLY_W'(fld.dly_code) + DLY_BASE;
    wait_cfg         = fld.wait_cfg;
    burst_seq        = fld.burst_seq;
    rise_edge        = fld.rise_edge;
    ind_latency      = fld.ind_lat;
    burst_len        = fld.burst_len;
  end

  AST_DLY_FLOOR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (burst_delay_clks >= DLY_BASE)); // R4

endmodule

// File: tb/flash_cfg_port_tb.sv
module flash_cfg_port_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_vld;
  logic [1:0]  cmd_op;
  logic [0:0]  cmd_bank;
  logic [31:0] cmd_data;
  logic        word_mode;
  logic        busy;
  logic        rd_req;
  logic [0:0]  rd_bank;
  logic [31:0] arr_data;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        rd_is_cfg;
  logic [15:0] cfg_word;
  logic        sync_burst_en;
  logic [4:0]  burst_delay_clks;
  logic        wait_cfg;
  logic        burst_seq;
  logic        rise_edge;
  logic        ind_latency;
  logic [2:0]  burst_len;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  flash_cfg_port u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_data(cmd_data), .word_mode(word_mode),
    .busy(busy), .rd_req(rd_req), .rd_bank(rd_bank), .arr_data(arr_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_is_cfg(rd_is_cfg),
    .cfg_word(cfg_word), .sync_burst_en(sync_burst_en),
    .burst_delay_clks(burst_delay_clks), .wait_cfg(wait_cfg),
    .burst_seq(burst_seq), .rise_edge(rise_edge),
    .ind_latency(ind_latency), .burst_len(burst_len)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Command held for one rising edge; outputs checked at the next falling edge
  task automatic do_cmd(input logic [1:0] op, input logic [0:0] bank,
                        input logic [31:0] data);
    @(negedge clk);
    cmd_vld = 1'b1; cmd_op = op; cmd_bank = bank; cmd_data = data;
    @(negedge clk);
    cmd_vld = 1'b0; cmd_op = 2'b00;
  endtask

  // Read issued at a falling edge, result sampled one clock later
  task automatic do_read(input logic [0:0] bank, output logic [31:0] d,
                         output logic is_cfg, output logic vld);
    @(negedge clk);
    rd_req = 1'b1; rd_bank = bank;
    @(negedge clk);
    rd_req = 1'b0;
    d = rd_data; is_cfg = rd_is_cfg; vld = rd_valid;
  endtask

  task automatic check_fields(input string req, input logic [15:0] w);
    check(req, "cfg_word", {16'h0, cfg_word}, {16'h0, w});
    check(req, "sync_burst_en", {31'h0, sync_burst_en}, {31'h0, !w[15]});
    check(req, "burst_delay_clks", {27'h0, burst_delay_clks},
          {27'h0, 5'({1'b0, w[13:10]}) + 5'd2});
    check(req, "wait_cfg", {31'h0, wait_cfg}, {31'h0, w[8]});
    check(req, "burst_seq", {31'h0, burst_seq}, {31'h0, w[7]});
    check(req, "rise_edge", {31'h0, rise_edge}, {31'h0, w[6]});
    check(req, "ind_latency", {31'h0, ind_latency}, {31'h0, w[3]});
    check(req, "burst_len", {29'h0, burst_len}, {29'h0, w[2:0]});
  endtask

  task automatic hw_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [31:0] d; logic c; logic v;
    hw_reset();
    check("R1", "reset word", {16'h0, cfg_word}, 32'h0000_9C40);
    check("R1", "reset sync_burst_en", {31'h0, sync_burst_en}, 32'h0);
    check("R1", "reset delay", {27'h0, burst_delay_clks}, 32'd9);
    check("R1", "reset rise_edge", {31'h0, rise_edge}, 32'h1);
    check("R8", "idle rd_valid", {31'h0, rd_valid}, 32'h0);
    arr_data = 32'hCAFE_1234;
    do_read(1'b0, d, c, v);
    check("R1", "reset read data", d, 32'hCAFE_1234);
    check("R1", "reset read cfg flag", {31'h0, c}, 32'h0);
  endtask

  task automatic t_write_fields();
    do_cmd(2'b01, 1'b0, 32'hABCD_0C85);
    check_fields("R2", 16'h0C85);
    check("R4", "delay code 3", {27'h0, burst_delay_clks}, 32'd5);
    check("R4", "sync enabled", {31'h0, sync_burst_en}, 32'h1);
    check("R4", "falling edge", {31'h0, rise_edge}, 32'h0);
    do_cmd(2'b01, 1'b1, 32'hFFFF_FFFF);
    check_fields("R4", 16'hBDCF);
    check("R4", "delay code 15", {27'h0, burst_delay_clks}, 32'd17);
  endtask

  task automatic t_busy_drop();
    do_cmd(2'b01, 1'b0, 32'h0000_0C85);
    busy = 1'b1;
    do_cmd(2'b01, 1'b0, 32'h0000_0000);
    busy = 1'b0;
    check_fields("R3", 16'h0C85);
    @(negedge clk);
    check("R3", "held after busy write", {16'h0, cfg_word}, 32'h0000_0C85);
  endtask

  task automatic t_reserved();
    do_cmd(2'b01, 1'b0, 32'h0000_4230);
    check("R5", "reserved only", {16'h0, cfg_word}, 32'h0000_0000);
    do_cmd(2'b01, 1'b0, 32'h0000_FFFF);
    check("R5", "all ones", {16'h0, cfg_word}, 32'h0000_BDCF);
  endtask

  task automatic t_bank_readback();
    logic [31:0] d; logic c; logic v;
    word_mode = 1'b0;
    arr_data  = 32'h1357_9BDF;
    do_cmd(2'b01, 1'b0, 32'h0000_0C85);
    do_cmd(2'b10, 1'b1, 32'h0);
    do_read(1'b1, d, c, v);
    check("R6", "bank1 cfg data", d, 32'h0000_0C85);
    check("R6", "bank1 cfg flag", {31'h0, c}, 32'h1);
    do_read(1'b0, d, c, v);
    check("R6", "bank0 array data", d, 32'h1357_9BDF);
    check("R6", "bank0 cfg flag", {31'h0, c}, 32'h0);
  endtask

  task automatic t_mode_persist();
    logic [31:0] d; logic c; logic v;
    do_cmd(2'b01, 1'b0, 32'h0000_8083);
    do_read(1'b1, d, c, v);
    check("R10", "new write visible", d, 32'h0000_8083);
    check("R7", "mode kept after write", {31'h0, c}, 32'h1);
    do_cmd(2'b10, 1'b0, 32'h0);
    do_read(1'b0, d, c, v);
    check("R7", "moved to bank0", d, 32'h0000_8083);
    do_read(1'b1, d, c, v);
    check("R7", "bank1 now array", d, 32'h1357_9BDF);
    do_cmd(2'b11, 1'b0, 32'h0);
    do_read(1'b0, d, c, v);
    check("R7", "array cmd exits", d, 32'h1357_9BDF);
    check("R7", "array cmd flag", {31'h0, c}, 32'h0);
    do_cmd(2'b10, 1'b1, 32'h0);
    hw_reset();
    do_read(1'b1, d, c, v);
    check("R7", "hw reset exits", {31'h0, c}, 32'h0);
  endtask

  task automatic t_read_timing();
    logic [31:0] d; logic c; logic v;
    arr_data = 32'h0F0F_A5A5;
    do_read(1'b0, d, c, v);
    check("R8", "valid one clock after", {31'h0, v}, 32'h1);
    check("R8", "data one clock after", d, 32'h0F0F_A5A5);
    arr_data = 32'h1111_2222;
    @(negedge clk);
    check("R8", "valid low without req", {31'h0, rd_valid}, 32'h0);
  endtask

  task automatic t_word_mode();
    logic [31:0] d; logic c; logic v;
    word_mode = 1'b1;
    arr_data  = 32'h1234_5678;
    do_read(1'b0, d, c, v);
    check("R9", "word mode array", d, 32'h0000_5678);
    word_mode = 1'b0;
    do_read(1'b0, d, c, v);
    check("R9", "dword mode array", d, 32'h1234_5678);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cmd_vld = 1'b0; cmd_op = 2'b00; cmd_bank = 1'b0;
    cmd_data = '0; word_mode = 1'b0; busy = 1'b0; rd_req = 1'b0;
    rd_bank = 1'b0; arr_data = '0;
    t_reset_state();
    t_write_fields();
    t_busy_drop();
    t_reserved();
    t_bank_readback();
    t_mode_persist();
    t_read_timing();
    t_word_mode();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule